// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block holds the pointer state of two independent address generators. Each generator owns four index registers, four modify (step) registers and four length registers. Each index register also has a hidden base register, which takes the value written to the index register. A modify command picks one generator and, inside it, one index register and one modify register. It adds the signed step to the pointer and folds the sum back into the circular buffer described by that index's base and length. It then stores the result in the index register. No memory access is made; only the pointer moves.

A mode register sits beside the generators. When its bit-reverse flag is set, the address presented for the first generator comes out with its bits in reverse order. This suits FFT-style reordering. The stored pointer always keeps natural order, and the second generator is never reversed. Software-side logic loads every register through a single write port. The result of each modify appears on a registered address output one cycle later.

Top module: `circ_agen`

## Requirements
- R1: A modify adds the signed 14-bit step M to the selected index I. When the paired length L is nonzero, a sum at or above base+L has L subtracted, a sum below base has L added, and the result is stored back into I. The base is the last value written to that index.
- R2: When the paired length is zero, the modify is linear: the stored result is (I+M) modulo 2^14, with no folding.
- R3: The write port takes effect on the next clock edge. wr_sel code 0 writes index register wr_idx of generator wr_gen and also sets that index's base. Code 1 writes a modify register, code 2 writes a length register, and code 3 writes the 7-bit mode register from wr_data[6:0], ignoring wr_gen and wr_idx.
- R4: mod_gen (0 = first generator, 1 = second) chooses the generator. mod_i and mod_m choose registers only within that generator, in any combination. Registers of the other generator are left unchanged.
- R5: One cycle after a cycle with mod_en high, addr_vld is 1 and addr_out shows the new pointer. After a cycle with mod_en low, addr_vld is 0 and addr_out keeps its value.
- R6: When mode bit 1 is set, addr_out for a first-generator modify carries the 14 result bits in reverse order (bit 0 to bit 13). The stored pointer keeps natural order. Second-generator results and all other mode bits never cause reversal.
- R7: After reset, every index, modify, length, base and mode register is zero, addr_vld is 0 and addr_out is 0.
- R8: If a write to an index register lands in the same cycle as a modify of that same index, the written value is stored. addr_out still shows the computed modify result.
- R9: A modify never changes any modify or length register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 index, 1 modify, 2 length, 3 mode |
| wr_gen | input | 1 | Generator for the write |
| wr_idx | input | 2 | Register number within the generator |
| wr_data | input | 14 | Write value |
| mod_en | input | 1 | Modify command strobe |
| mod_gen | input | 1 | Generator for the modify |
| mod_i | input | 2 | Index register number within the generator |
| mod_m | input | 2 | Modify register number within the generator |
| addr_vld | output | 1 | addr_out was updated by the previous cycle's modify |
| addr_out | output | 14 | Modified pointer, reversed when mode bit 1 is set for the first generator |

## Verification
The bench goes after several fold boundaries:
- A sum landing exactly on base+L must fold to base. An off-by-one compare would return base+L instead.
- A negative step falling below base must add L. A design that only checks the upper bound would leave the pointer outside the buffer.
- Linear mode must roll over 0 and 2^14-1. A design that folds on a zero length would return garbage there.

Further checks cover reversal only for the first generator and only on the output. A design that stored the reversed value would show a different address on a repeated zero-step modify. A write colliding with a modify must win, and registers of the other generator must stay untouched.

// File: rtl/circ_agen_pkg.sv
package circ_agen_pkg;

    localparam int ADDR_W_DEF = 14;
    localparam int NREG_DEF   = 4;
    localparam int NGEN_DEF   = 2;
    localparam int MODE_W_DEF = 7;

    typedef enum logic [1:0] {
        SEL_IDX  = 2'd0,
        SEL_MOD  = 2'd1,
        SEL_LEN  = 2'd2,
        SEL_MODE = 2'd3
    } wsel_e;

endpackage

// File: rtl/circ_agen_wrap.sv
module circ_agen_wrap #(
    parameter int AW = 14
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] mdf,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] bse,
    output logic [AW-1:0] res
);
    localparam int SW = AW + 2;

    logic [SW-1:0] sum;
    logic [SW-1:0] lo;
    logic [SW-1:0] hi;
    logic [SW-1:0] ext_len;
    logic [SW-1:0] folded;

    assign ext_len = {2'b00, len};
    assign sum     = {2'b00, idx} + {{2{mdf[AW-1]}}, mdf};
    assign lo      = {2'b00, bse};
    assign hi      = lo + ext_len;

    always_comb begin
        if (len == '0) begin
            folded = sum;
        end else if ($signed(sum) >= $signed(hi)) begin
            folded = sum - ext_len;
        end else if ($signed(sum) < $signed(lo)) begin
            folded = sum + ext_len;
        end else begin
            folded = sum;
        end
        res = folded[AW-1:0];
    end

endmodule

// File: rtl/circ_agen_bank.sv
module circ_agen_bank
    import circ_agen_pkg::*;
#(
    parameter int AW   = ADDR_W_DEF,
    parameter int NREG = NREG_DEF,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic          mod_en,
    input  logic [IW-1:0] mod_i,
    input  logic [IW-1:0] mod_m,
    output logic [AW-1:0] upd
);
    typedef struct packed {
        logic [NREG-1:0][AW-1:0] idx;
        logic [NREG-1:0][AW-1:0] mdf;
        logic [NREG-1:0][AW-1:0] len;
        logic [NREG-1:0][AW-1:0] bse;
    } bank_t;

    bank_t st_d, st_q;
    logic [AW-1:0] res;

    circ_agen_wrap #(.AW(AW)) wrap_i (
        .idx (st_q.idx[mod_i]),
        .mdf (st_q.mdf[mod_m]),
        .len (st_q.len[mod_i]),
        .bse (st_q.bse[mod_i]),
        .res (res)
    );

    assign upd = res;

    always_comb begin
        st_d = st_q;
        if (mod_en) begin
            st_d.idx[mod_i] = res;
        end
        if (wr_en) begin
            case (wr_sel)
                SEL_IDX: begin
                    st_d.idx[wr_idx] = wr_data;
                    st_d.bse[wr_idx] = wr_data;
                end
                SEL_MOD: st_d.mdf[wr_idx] = wr_data;
                SEL_LEN: st_d.len[wr_idx] = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // in-buffer window check helpers
    logic [AW+1:0] cur_w, lo_w, hi_w, res_w, step_mag;
    logic [AW-1:0] cur_mdf;
    assign cur_mdf  = st_q.mdf[mod_m];
    assign cur_w    = {2'b00, st_q.idx[mod_i]};
    assign lo_w     = {2'b00, st_q.bse[mod_i]};
    assign hi_w     = lo_w + {2'b00, st_q.len[mod_i]};
    assign res_w    = {2'b00, res};
    assign step_mag = cur_mdf[AW-1] ? {2'b00, (~cur_mdf + 1'b1)} : {2'b00, cur_mdf};

    p_stay_in_buf_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && st_q.len[mod_i] != '0 && cur_w >= lo_w && cur_w < hi_w
         && step_mag < {2'b00, st_q.len[mod_i]})
        |-> (res_w >= lo_w && res_w < hi_w));

    p_base_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_IDX) |=> st_q.bse[$past(wr_idx)] == $past(wr_data));

    p_mod_keeps_ml_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && !wr_en) |=> ($stable(st_q.mdf) && $stable(st_q.len)));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_en && !wr_en) |=> $stable(st_q));

endmodule

// File: rtl/circ_agen.sv
module circ_agen
    import circ_agen_pkg::*;
#(
    parameter int AW      = ADDR_W_DEF,
    parameter int NREG    = NREG_DEF,
    parameter int NGEN    = NGEN_DEF,
    parameter int MODE_W  = MODE_W_DEF,
    parameter int REV_BIT = 1,
    parameter int REV_GEN = 0,
    localparam int IW     = $clog2(NREG),
    localparam int GW     = $clog2(NGEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [GW-1:0] wr_gen,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic          mod_en,
    input  logic [GW-1:0] mod_gen,
    input  logic [IW-1:0] mod_i,
    input  logic [IW-1:0] mod_m,
    output logic          addr_vld,
    output logic [AW-1:0] addr_out
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              vld;
        logic [AW-1:0]     addr;
    } top_t;

    top_t top_d, top_q;

    logic [AW-1:0] bank_upd [NGEN];
    logic [AW-1:0] upd;
    logic [AW-1:0] upd_rev;
    logic          rev_sel;
    logic          wr_mode;

    assign wr_mode = wr_en && (wr_sel == SEL_MODE);

    for (genvar g = 0; g < NGEN; g++) begin : g_bank
        circ_agen_bank #(.AW(AW), .NREG(NREG)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && !wr_mode && (wr_gen == GW'(g))),
            .wr_sel  (wr_sel),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .mod_en  (mod_en && (mod_gen == GW'(g))),
            .mod_i   (mod_i),
            .mod_m   (mod_m),
            .upd     (bank_upd[g])
        );
    end

    assign upd = bank_upd[mod_gen];

    for (genvar b = 0; b < AW; b++) begin : g_rev
        assign upd_rev[b] = upd[AW-1-b];
    end

    assign rev_sel = top_q.mode[REV_BIT] && (mod_gen == GW'(REV_GEN));

    always_comb begin
        top_d     = top_q;
        top_d.vld = mod_en;
        if (mod_en) begin
            top_d.addr = rev_sel ? upd_rev : upd;
        end
        if (wr_mode) begin
            top_d.mode = wr_data[MODE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign addr_vld = top_q.vld;
    assign addr_out = top_q.addr;

    p_vld_after_mod_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mod_en |=> addr_vld);

    p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> (!addr_vld && $stable(addr_out)));

    p_rev_keeps_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mod_en |=> $countones(addr_out) == $countones($past(upd)));

endmodule

// File: tb/circ_agen_tb_top.sv
`timescale 1ns/1ps
module circ_agen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic        wr_gen = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [13:0] wr_data = '0;
    logic        mod_en = 1'b0;
    logic        mod_gen = 1'b0;
    logic [1:0]  mod_i = '0;
    logic [1:0]  mod_m = '0;
    logic        addr_vld;
    logic [13:0] addr_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    circ_agen dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_gen(wr_gen), .wr_idx(wr_idx), .wr_data(wr_data),
        .mod_en(mod_en), .mod_gen(mod_gen), .mod_i(mod_i), .mod_m(mod_m),
        .addr_vld(addr_vld), .addr_out(addr_out)
    );

    typedef struct packed {
        logic        gen;
        logic [1:0]  idx;
        logic [13:0] ival;
        logic [13:0] mval;
        logic [13:0] lval;
        logic [3:0]  n;
        logic [13:0] exp;
    } vec_t;

    // gen, idx, I, M, L, modify count, expected pointer
    localparam vec_t VEC [8] = '{
        '{1'b0, 2'd0, 14'd100,   14'd3,     14'd10, 4'd4, 14'd102},   // R1 upper fold
        '{1'b0, 2'd1, 14'd100,   14'd16381, 14'd10, 4'd1, 14'd107},   // R1 below base
        '{1'b1, 2'd2, 14'd50,    14'd7,     14'd0,  4'd3, 14'd71},    // R2 linear
        '{1'b1, 2'd3, 14'd16383, 14'd1,     14'd0,  4'd1, 14'd0},     // R2 rollover up
        '{1'b0, 2'd2, 14'd2000,  14'd5,     14'd5,  4'd1, 14'd2000},  // R1 exactly base+L
        '{1'b1, 2'd0, 14'd300,   14'd16383, 14'd0,  4'd2, 14'd298},   // R2 negative step
        '{1'b1, 2'd1, 14'd0,     14'd16383, 14'd0,  4'd1, 14'd16383}, // R2 rollover down
        '{1'b0, 2'd3, 14'd8,     14'd4,     14'd12, 4'd5, 14'd16}     // R1 R9 repeated fold
    };

    task automatic chk(input string req, input logic [13:0] got, input logic [13:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic g, input logic [1:0] i, input logic [13:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_gen = g; wr_idx = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic mdfy(input logic g, input logic [1:0] i, input logic [1:0] m);
        mod_en = 1'b1; mod_gen = g; mod_i = i; mod_m = m;
        @(negedge clk);
        mod_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R7 reset state
        chk("R7 addr_vld at reset", {13'd0, addr_vld}, 14'd0);
        chk("R7 addr_out at reset", addr_out, 14'd0);
        rst_n = 1'b1;
        @(negedge clk);
        mdfy(1'b1, 2'd2, 2'd2);
        chk("R7 reset pointer", addr_out, 14'd0);
        chk("R5 vld after modify", {13'd0, addr_vld}, 14'd1);

        // vector table
        for (int k = 0; k < 8; k++) begin
            wr(2'd0, VEC[k].gen, VEC[k].idx, VEC[k].ival);
            wr(2'd1, VEC[k].gen, VEC[k].idx, VEC[k].mval);
            wr(2'd2, VEC[k].gen, VEC[k].idx, VEC[k].lval);
            for (int r = 0; r < int'(VEC[k].n); r++) mdfy(VEC[k].gen, VEC[k].idx, VEC[k].idx);
            chk($sformatf("R1 R2 R3 vector %0d", k), addr_out, VEC[k].exp);
        end

        // R5 idle cycle: vld drops, address holds
        @(negedge clk);
        chk("R5 vld low when idle", {13'd0, addr_vld}, 14'd0);
        chk("R5 addr holds when idle", addr_out, 14'd16);

        // R4 isolation and free pairing inside a generator
        wr(2'd0, 1'b0, 2'd1, 14'd500);
        wr(2'd1, 1'b0, 2'd1, 14'd10);
        wr(2'd2, 1'b0, 2'd1, 14'd0);
        wr(2'd0, 1'b1, 2'd1, 14'd600);
        wr(2'd1, 1'b1, 2'd1, 14'd0);
        wr(2'd2, 1'b1, 2'd1, 14'd0);
        mdfy(1'b0, 2'd1, 2'd1);
        chk("R4 first generator step", addr_out, 14'd510);
        mdfy(1'b1, 2'd1, 2'd1);
        chk("R4 other generator untouched", addr_out, 14'd600);
        wr(2'd0, 1'b1, 2'd2, 14'd40);
        wr(2'd2, 1'b1, 2'd2, 14'd0);
        wr(2'd1, 1'b1, 2'd0, 14'd2);
        mdfy(1'b1, 2'd2, 2'd0);
        chk("R4 cross pairing I2 with M0", addr_out, 14'd42);

        // R6 bit reversal (mode bit 1)
        wr(2'd0, 1'b0, 2'd0, 14'd1);
        wr(2'd1, 1'b0, 2'd0, 14'd0);
        wr(2'd2, 1'b0, 2'd0, 14'd0);
        wr(2'd3, 1'b1, 2'd3, 14'd2);
        mdfy(1'b0, 2'd0, 2'd0);
        chk("R6 reversed output", addr_out, 14'd8192);
        mdfy(1'b0, 2'd0, 2'd0);
        chk("R6 stored pointer natural order", addr_out, 14'd8192);
        wr(2'd0, 1'b0, 2'd0, 14'd3);
        mdfy(1'b0, 2'd0, 2'd0);
        chk("R6 reversed value 3", addr_out, 14'd12288);
        wr(2'd0, 1'b1, 2'd0, 14'd1);
        wr(2'd1, 1'b1, 2'd0, 14'd0);
        wr(2'd2, 1'b1, 2'd0, 14'd0);
        mdfy(1'b1, 2'd0, 2'd0);
        chk("R6 second generator never reversed", addr_out, 14'd1);
        wr(2'd3, 1'b0, 2'd0, 14'h7D);
        mdfy(1'b0, 2'd0, 2'd0);
        chk("R6 other mode bits no reversal", addr_out, 14'd3);
        wr(2'd3, 1'b0, 2'd0, 14'd0);

        // R8 write and modify collide on the same index
        wr(2'd0, 1'b0, 2'd0, 14'd10);
        wr(2'd1, 1'b0, 2'd0, 14'd1);
        mod_en = 1'b1; mod_gen = 1'b0; mod_i = 2'd0; mod_m = 2'd0;
        wr_en = 1'b1; wr_sel = 2'd0; wr_gen = 1'b0; wr_idx = 2'd0; wr_data = 14'd77;
        @(negedge clk);
        mod_en = 1'b0; wr_en = 1'b0;
        chk("R8 output shows computed result", addr_out, 14'd11);
        mdfy(1'b0, 2'd0, 2'd0);
        chk("R8 written value kept", addr_out, 14'd78);

        // R9 modify leaves length and step intact: fold repeats identically
        wr(2'd0, 1'b1, 2'd3, 14'd20);
        wr(2'd1, 1'b1, 2'd3, 14'd6);
        wr(2'd2, 1'b1, 2'd3, 14'd8);
        mdfy(1'b1, 2'd3, 2'd3);
        chk("R9 first step", addr_out, 14'd26);
        mdfy(1'b1, 2'd3, 2'd3);
        chk("R9 second step folds with same L", addr_out, 14'd24);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule